// File: doc/BRIEF.md
# Split-Latency Synchronous RAM

This block is a synchronous RAM with one write port and one read port. Its read latency is made of two stages around the storage array. The first stage is a register chain on the read request (address and enable), so the array is looked up some cycles after the read is issued. The second stage is a register chain on the word taken from the array, which adds cycles between the lookup and the output. The sum of the two is the latency a user sees. How the sum is divided decides which earlier writes a read can observe. A request-side delay lets late writes reach the read. A data-side delay freezes the word at issue time.

A mode parameter puts the whole latency on the request side, or the whole latency on the data side, or takes both counts as two separate parameters. Writes update the array at the clock edge on which the write enable is high. A byte mask chooses which bytes of the word are changed. A valid flag travels with every read through both stages. When no read completes, the output word keeps the last word delivered.

Top module: `splitlat_ram`

## Requirements
- R1: `rd_valid` is high in exactly the cycle that lies PRE+POST cycles after a cycle in which `rd_en` was high, and low in every other cycle.
- R2: A write changes only the bytes whose `wr_be` bit is set. Bit k of `wr_be` controls `wr_data[8k+7:8k]` (BYTE_W = 8).
- R3: With LAT_MODE = LAT_ALL_PRE (PRE = TOTAL_LAT, POST = 0), a read issued in cycle t returns the word that includes every write issued in cycles before t+TOTAL_LAT.
- R4: With LAT_MODE = LAT_ALL_POST (PRE = 0, POST = TOTAL_LAT), a read issued in cycle t returns the word that includes only the writes issued in cycles before t.
- R5: With LAT_MODE = LAT_CUSTOM, PRE = CUST_PRE and POST = CUST_POST are set separately. A read issued in cycle t returns the word that includes the writes issued before cycle t+PRE.
- R6: With PRE = POST = 0, `rd_valid` follows `rd_en` in the same cycle, and `rd_data` shows the array word at `rd_addr` combinationally.
- R7: A write to the address being looked up, in the lookup cycle itself, is not seen by that read (read-first).
- R8: While `rd_valid` is low, `rd_data` holds the last word delivered, or zero if no word has been delivered since reset.
- R9: An active-low reset clears every in-flight read and the held output word right away. The array contents are kept, and reads after reset return the words written before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_be | input | DATA_W/BYTE_W | Byte mask, one bit per byte lane |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, held while rd_valid is low |
| rd_valid | output | 1 | Read data is valid in this cycle |

## Verification
The hardest case to reach is a read whose address is written several times while the read is in flight. Only then do the splits of the same total latency give different words: one for a request-side delay, one for a data-side delay, one for a mixed split. The bench drives four copies of the block with the same stimulus: all-pre, all-post, a one-and-one split, and zero latency. It uses a directed sequence of back-to-back writes to one address around a single read. Random traffic then runs on a small address space, so that collisions with reads in flight happen often. A reset in the middle of traffic checks that reads in flight are dropped while the stored words survive.

// File: rtl/splitlat_pkg.sv
package splitlat_pkg;
  typedef enum logic [1:0] {
    LAT_ALL_PRE  = 2'd0,
    LAT_ALL_POST = 2'd1,
    LAT_CUSTOM   = 2'd2
  } lat_mode_e;
endpackage

// File: rtl/splitlat_pipe.sv
// Valid-qualified delay chain: DEPTH register stages, the payload loads only with valid.
module splitlat_pipe #(
  parameter int DEPTH = 1,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_dat,
  output logic         out_vld,
  output logic [W-1:0] out_dat
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign out_vld = in_vld;
      assign out_dat = in_dat;
    end else begin : g_chain
      for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        logic         src_v;
        logic [W-1:0] src_d;
        logic         v_d, v_q;
        logic [W-1:0] d_d, d_q;
        if (k == 0) begin : g_head
          assign src_v = in_vld;
          assign src_d = in_dat;
        end else begin : g_link
          assign src_v = g_stage[k-1].v_q;
          assign src_d = g_stage[k-1].d_q;
        end
        always_comb begin
          v_d = src_v;
          d_d = src_v ? src_d : d_q;
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) v_q <= 1'b0;
          else        v_q <= v_d;
        end
        always_ff @(posedge clk) begin
          d_q <= d_d;
        end
      end
      assign out_vld = g_stage[DEPTH-1].v_q;
      assign out_dat = g_stage[DEPTH-1].d_q;
    end
  endgenerate
endmodule

// File: rtl/splitlat_array.sv
// Storage split into byte lanes; asynchronous lookup, write at the clock edge.
module splitlat_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W/BYTE_W-1:0] wbe,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [DATA_W-1:0]        rdata
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NLANES = DATA_W / BYTE_W;

  generate
    for (genvar b = 0; b < NLANES; b++) begin : g_lane
      logic [BYTE_W-1:0] lane_q [DEPTH];
      logic              lane_we;
      assign lane_we = we & wbe[b];
      always_ff @(posedge clk) begin
        if (lane_we) lane_q[waddr] <= wdata[b*BYTE_W +: BYTE_W];
      end
      assign rdata[b*BYTE_W +: BYTE_W] = lane_q[raddr];
    end
  endgenerate
endmodule

// File: rtl/splitlat_ram.sv
module splitlat_ram #(
  parameter int                      ADDR_W    = 6,
  parameter int                      DATA_W    = 32,
  parameter int                      BYTE_W    = 8,
  parameter splitlat_pkg::lat_mode_e LAT_MODE  = splitlat_pkg::LAT_ALL_PRE,
  parameter int                      TOTAL_LAT = 2,
  parameter int                      CUST_PRE  = 1,
  parameter int                      CUST_POST = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [DATA_W/BYTE_W-1:0] wr_be,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid
);
  localparam int PRE_N  = (LAT_MODE == splitlat_pkg::LAT_ALL_PRE)  ? TOTAL_LAT :
                          (LAT_MODE == splitlat_pkg::LAT_ALL_POST) ? 0 : CUST_PRE;
  localparam int POST_N = (LAT_MODE == splitlat_pkg::LAT_ALL_PRE)  ? 0 :
                          (LAT_MODE == splitlat_pkg::LAT_ALL_POST) ? TOTAL_LAT : CUST_POST;

  logic              probe_vld;
  logic [ADDR_W-1:0] probe_addr;
  logic [DATA_W-1:0] array_word;
  logic              out_vld;
  logic [DATA_W-1:0] out_word;
  logic [DATA_W-1:0] hold_d, hold_q;

  // Request-side delay: the array is looked up PRE_N cycles after issue.
  splitlat_pipe #(.DEPTH(PRE_N), .W(ADDR_W)) u_pre (
    .clk(clk), .rst_n(rst_n),
    .in_vld(rd_en), .in_dat(rd_addr),
    .out_vld(probe_vld), .out_dat(probe_addr)
  );

  splitlat_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_array (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data), .wbe(wr_be),
    .raddr(probe_addr), .rdata(array_word)
  );

  // Data-side delay: the looked-up word travels POST_N stages to the output.
  splitlat_pipe #(.DEPTH(POST_N), .W(DATA_W)) u_post (
    .clk(clk), .rst_n(rst_n),
    .in_vld(probe_vld), .in_dat(array_word),
    .out_vld(out_vld), .out_dat(out_word)
  );

  always_comb begin
    hold_d = out_vld ? out_word : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign rd_valid = out_vld;
  assign rd_data  = out_vld ? out_word : hold_q;
endmodule

// File: rtl/splitlat_ram_chk.sv
module splitlat_ram_chk #(
  parameter int PRE_N  = 2,
  parameter int POST_N = 0,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              probe_vld
);
  localparam int TOT = PRE_N + POST_N;
  localparam int SW  = (TOT > 0) ? TOT : 1;

  logic [SW-1:0] sh_q;
  logic          past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      past_ok <= 1'b0;
    end else begin
      sh_q    <= {sh_q[SW-1:0], rd_en} >> 0;
      past_ok <= 1'b1;
    end
  end

  generate
    if (TOT > 0) begin : g_lat
      // R1: valid comes out exactly TOT cycles after the request
      assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == sh_q[TOT-1]);
      // R9: reset drops every read in flight
      assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |-> !rd_valid);
    end
    if (PRE_N > 0) begin : g_pre
      // R5: the lookup happens PRE_N cycles after issue
      assert_probe_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
        probe_vld == sh_q[PRE_N-1]);
    end
  endgenerate

  // R8: output word is stable while no read completes
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !rd_valid) |-> $stable(rd_data));
endmodule

bind splitlat_ram splitlat_ram_chk #(
  .PRE_N(PRE_N), .POST_N(POST_N), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid),
  .rd_data(rd_data), .probe_vld(probe_vld)
);

// File: tb/splitlat_ram_tb.sv
module splitlat_ram_tb;
  localparam int AW = 3;
  localparam int DW = 32;
  localparam int NB = DW / 8;
  localparam int NI = 4;

  logic clk;
  logic rst_n;
  logic wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data;
  logic [NB-1:0] wr_be;
  logic [DW-1:0] rdat [NI];
  logic          rv   [NI];

  int tests, fails;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Instance 0: all pre, 1: all post, 2: one and one, 3: zero latency.
  splitlat_ram #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(8),
    .LAT_MODE(splitlat_pkg::LAT_ALL_PRE), .TOTAL_LAT(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rdat[0]), .rd_valid(rv[0]));
  splitlat_ram #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(8),
    .LAT_MODE(splitlat_pkg::LAT_ALL_POST), .TOTAL_LAT(2)) u_dut_post (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rdat[1]), .rd_valid(rv[1]));
  splitlat_ram #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(8),
    .LAT_MODE(splitlat_pkg::LAT_CUSTOM), .CUST_PRE(1), .CUST_POST(1)) u_dut_mid (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rdat[2]), .rd_valid(rv[2]));
  splitlat_ram #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(8),
    .LAT_MODE(splitlat_pkg::LAT_CUSTOM), .CUST_PRE(0), .CUST_POST(0)) u_dut_zero (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rdat[3]), .rd_valid(rv[3]));

  int    pre_of [NI] = '{2, 0, 1, 0};
  int    tot_of [NI] = '{2, 2, 2, 0};
  string tag_of [NI] = '{"R3", "R4", "R5", "R6"};

  logic [DW-1:0] ref_mem [1 << AW];
  logic          hist_en   [8];
  logic [AW-1:0] hist_addr [8];
  logic          exp_v  [NI][8];
  logic [DW-1:0] exp_d  [NI][8];
  logic          exp_rf [NI][8];
  logic [DW-1:0] last_d [NI];
  int            cyc;
  string         tag_ovr;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                          logic [NB-1:0] be);
    logic [DW-1:0] r = old_w;
    for (int b = 0; b < NB; b++) if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
    return r;
  endfunction

  task automatic check(bit ok, string tag, int inst, logic [DW-1:0] got, logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s inst%0d cycle %0d: got %h expected %h", tag, inst, cyc, got, exp);
    end
  endtask

  task automatic clear_model();
    for (int s = 0; s < 8; s++) begin
      hist_en[s] = 1'b0;
      for (int i = 0; i < NI; i++) exp_v[i][s] = 1'b0;
    end
    for (int i = 0; i < NI; i++) last_d[i] = '0;
  endtask

  // One clock cycle: drive, predict, compare, then commit the write in the model.
  task automatic step(logic ren, logic [AW-1:0] ra, logic wen, logic [AW-1:0] wa,
                      logic [DW-1:0] wd, logic [NB-1:0] be);
    @(negedge clk);
    rd_en = ren; rd_addr = ra; wr_en = wen; wr_addr = wa; wr_data = wd; wr_be = be;
    hist_en[cyc % 8] = ren; hist_addr[cyc % 8] = ra;
    #1;
    for (int i = 0; i < NI; i++) begin
      if (cyc >= pre_of[i] && hist_en[(cyc - pre_of[i]) % 8]) begin
        int due = cyc - pre_of[i] + tot_of[i];
        logic [AW-1:0] a = hist_addr[(cyc - pre_of[i]) % 8];
        exp_v[i][due % 8]  = 1'b1;
        exp_d[i][due % 8]  = ref_mem[a];
        exp_rf[i][due % 8] = wen && (wa == a) && (be != '0);
      end
      if (exp_v[i][cyc % 8]) begin
        string t = (tag_ovr != "") ? tag_ovr : (exp_rf[i][cyc % 8] ? "R7" : tag_of[i]);
        check(rv[i] === 1'b1, "R1", i, {31'd0, rv[i]}, 32'd1);
        check(rdat[i] === exp_d[i][cyc % 8], t, i, rdat[i], exp_d[i][cyc % 8]);
        last_d[i] = exp_d[i][cyc % 8];
        exp_v[i][cyc % 8] = 1'b0;
      end else begin
        check(rv[i] === 1'b0, "R1", i, {31'd0, rv[i]}, 32'd0);
        check(rdat[i] === last_d[i], "R8", i, rdat[i], last_d[i]);
      end
    end
    if (wen) ref_mem[wa] = merge(ref_mem[wa], wd, be);
    cyc++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    #1;
    for (int i = 0; i < NI; i++) begin
      check(rv[i] === 1'b0, "R9", i, {31'd0, rv[i]}, 32'd0);
      check(rdat[i] === '0, "R9", i, rdat[i], '0);
    end
    clear_model();
    @(negedge clk);
    rst_n = 1'b1;
    cyc += 2;
  endtask

  initial begin
    tests = 0; fails = 0; cyc = 0; tag_ovr = "";
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    rd_addr = '0; wr_addr = '0; wr_data = '0; wr_be = '0;
    clear_model();
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    do_reset();

    // Fill every word with full masks.
    for (int a = 0; a < (1 << AW); a++)
      step(1'b0, '0, 1'b1, AW'(a), 32'h1000_0000 + a, '1);

    // R2: partial masks, then read back.
    tag_ovr = "R2";
    step(1'b0, '0, 1'b1, 3'd2, 32'hAABB_CCDD, 4'b0101);
    step(1'b0, '0, 1'b1, 3'd2, 32'h1122_3344, 4'b0000);
    step(1'b0, '0, 1'b1, 3'd3, 32'hEEFF_0011, 4'b1000);
    step(1'b1, 3'd2, 1'b0, '0, '0, '0);
    step(1'b1, 3'd3, 1'b0, '0, '0, '0);
    repeat (3) step(1'b0, '0, 1'b0, '0, '0, '0);
    tag_ovr = "";

    // Ordering: one read of address 5 with writes to it in the cycles around it.
    step(1'b0, '0, 1'b1, 3'd5, 32'h0000_0001, '1);
    step(1'b1, 3'd5, 1'b1, 3'd5, 32'h0000_0002, '1);
    step(1'b0, '0, 1'b1, 3'd5, 32'h0000_0003, '1);
    step(1'b0, '0, 1'b1, 3'd5, 32'h0000_0004, '1);
    repeat (3) step(1'b0, '0, 1'b0, '0, '0, '0);

    // Back-to-back reads of one address while it is rewritten each cycle.
    for (int k = 0; k < 6; k++)
      step(1'b1, 3'd6, 1'b1, 3'd6, 32'hC0DE_0000 + k, '1);
    repeat (3) step(1'b0, '0, 1'b0, '0, '0, '0);

    // Random traffic on a small address space.
    for (int n = 0; n < 3000; n++)
      step(($urandom % 3) != 0, AW'($urandom), ($urandom % 2) == 0, AW'($urandom),
           $urandom, NB'($urandom));

    // R9: reset with reads in flight, then the stored words must still be there.
    step(1'b1, 3'd1, 1'b0, '0, '0, '0);
    step(1'b1, 3'd4, 1'b0, '0, '0, '0);
    do_reset();
    tag_ovr = "R9";
    for (int a = 0; a < (1 << AW); a++) step(1'b1, AW'(a), 1'b0, '0, '0, '0);
    repeat (3) step(1'b0, '0, 1'b0, '0, '0, '0);
    tag_ovr = "";

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule